// File: doc/BRIEF.md
# Instruction Issue and Skip Sequencer

This block decides, one cycle at a time, what the front end of a small processor with 24-bit instruction words does with the word it has just fetched. Each fetched word arrives with a handful of pre-decoded flags. The flags say whether the word starts a two-word instruction, whether it is a conditional skip, whether its condition is true, whether it redirects the program counter, and whether it belongs to one of three fixed multi-cycle classes. From these the sequencer works out how many cycles the instruction occupies and how many words it consumes. It marks the cycles that must be filled with bubbles, so downstream state is left untouched there.

A taken skip discards the instruction that follows it. A look-ahead flag tells the sequencer whether that instruction is one word or two, so the word pointer jumps past all of it. A word whose top eight bits are all zero is the tail of a two-word instruction. If such a word is ever presented on its own, it is retired as a one-cycle bubble. The fetch side presents a new word only while `busy` is low.

Top module: `issue_seq`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, clears `word_ptr` to 0, drops `busy`, and cancels every pending bubble or continuation cycle.
- R2: A plain single-word instruction, with all flags low and a nonzero top byte, gives one cycle with `issue_valid`=1, `nop_insert`=0 and `word_consume`=1.
- R3: A single-word instruction with `cond_true` or `pc_change` set, and no higher-priority flag, is issued and then followed by exactly one bubble cycle.
- R4: When `is_dword` is set, the issue cycle reports `word_consume`=2. It is followed by one continuation cycle with `busy`=1, `issue_valid`=0 and `nop_insert`=0. `is_dword` takes priority over the class, skip, condition and redirect flags.
- R5: `mc_class` codes 01, 10 and 11 make the instruction last CYC1, CYC2 and CYC3 cycles (default 2, 3, 3), all cycles after the first being bubbles, with `word_consume`=1. Code 00 means no class. This code takes priority over the skip, condition and redirect flags.
- R6: A skip with `cond_true` low lasts one cycle and consumes one word.
- R7: A taken skip consumes 2 words and is followed by one bubble when `next_dword`=0. When `next_dword`=1 it consumes 3 words and is followed by two bubbles.
- R8: A word whose bits [23:16] are zero is retired in one cycle with `issue_valid`=0, `nop_insert`=1 and `word_consume`=1, whatever its flags say. This rule takes priority over every flag.
- R9: In every bubble cycle `issue_valid`=0, `nop_insert`=1 and `word_consume`=0. `issue_valid` and `nop_insert` are never both high.
- R10: `busy` is high in every cycle after the issue cycle of a multi-cycle instruction. While it is high, the fetch inputs are ignored and no word is consumed.
- R11: `word_ptr` advances by `word_consume` at each clock edge and wraps modulo 2^PTR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | A fetched word is presented |
| fetch_word | input | WORD_W | Fetched instruction word |
| is_dword | input | 1 | Word starts a two-word instruction |
| is_skip | input | 1 | Instruction is a conditional skip |
| cond_true | input | 1 | Condition of the instruction evaluates true |
| pc_change | input | 1 | Instruction redirects the program counter |
| mc_class | input | 2 | Fixed multi-cycle class, 00 = none |
| next_dword | input | 1 | Look-ahead: the following instruction is two words |
| issue_valid | output | 1 | Instruction issued this cycle |
| nop_insert | output | 1 | Bubble cycle, no state update |
| word_consume | output | 2 | Words retired from the fetch stream this cycle |
| busy | output | 1 | Sequencer occupied; fetch inputs ignored |
| word_ptr | output | PTR_W | Running word pointer |

## Verification
The embedded properties check, on every cycle, that issue and bubble never coincide and that nothing is issued or consumed while busy. They also check that a taken skip or a two-word instruction is followed by the right kind of cycle, that a zero-tagged word is retired as a bubble, and that reset leaves the pointer at zero. Exact cycle counts per class, the three-cycle cost of skipping a two-word instruction, flag priority, pointer wraparound and reset in the middle of a multi-cycle instruction are shown only by the bench. Its reference model follows the expected issue, bubble, consume and busy pattern through directed and random instruction streams.

// File: rtl/issue_seq.sv
`timescale 1ns/1ps
module issue_seq #(
  parameter int WORD_W = 24,
  parameter int TAG_W  = 8,
  parameter int PTR_W  = 16,
  parameter int CYC1   = 2,
  parameter int CYC2   = 3,
  parameter int CYC3   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              is_dword,
  input  logic              is_skip,
  input  logic              cond_true,
  input  logic              pc_change,
  input  logic [1:0]        mc_class,
  input  logic              next_dword,
  output logic              issue_valid,
  output logic              nop_insert,
  output logic [1:0]        word_consume,
  output logic              busy,
  output logic [PTR_W-1:0]  word_ptr
);
  localparam int CNT_W = 2;

  logic [CNT_W-1:0] cnt;
  logic             cont;
  logic [CNT_W-1:0] total;
  logic [1:0]       words;

  wire accept  = fetch_valid && (cnt == '0);
  wire is_fill = (fetch_word[WORD_W-1 -: TAG_W] == '0);

  always_comb begin
    total = CNT_W'(1);
    words = 2'd1;
    if (is_fill) begin
      total = CNT_W'(1);
    end else if (is_dword) begin
      total = CNT_W'(2);
      words = 2'd2;
    end else if (mc_class != 2'b00) begin
      case (mc_class)
        2'b01:   total = CNT_W'(CYC1);
        2'b10:   total = CNT_W'(CYC2);
        default: total = CNT_W'(CYC3);
      endcase
    end else if (is_skip) begin
      total = cond_true ? (next_dword ? CNT_W'(3) : CNT_W'(2)) : CNT_W'(1);
      words = 2'(total);
    end else if (cond_true || pc_change) begin
      total = CNT_W'(2);
    end
  end

  assign issue_valid  = accept && !is_fill;
  assign nop_insert   = (accept && is_fill) || ((cnt != '0) && !cont);
  assign word_consume = accept ? words : 2'd0;
  assign busy         = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cont     <= 1'b0;
      word_ptr <= '0;
    end else begin
      word_ptr <= word_ptr + PTR_W'(word_consume);
      if (accept) begin
        cnt  <= total - CNT_W'(1);
        cont <= is_dword && !is_fill;
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> (word_ptr == '0) && !busy);

  // R9
  issue_nop_excl_chk: assert property (@(posedge clk) disable iff (rst) !(issue_valid && nop_insert));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !issue_valid && (word_consume == 2'd0));

  // R4
  dword_cont_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && is_dword) |=> busy && !nop_insert && !issue_valid);

  // R7
  skip_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !is_dword && mc_class == 2'b00 && is_skip && cond_true) |=> busy && nop_insert);

  // R8
  fill_word_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !busy && fetch_word[WORD_W-1 -: TAG_W] == '0) |-> nop_insert && !issue_valid && word_consume == 2'd1);
endmodule

// File: tb/issue_seq_tb.sv
`timescale 1ns/1ps
module issue_seq_tb;
  localparam int PW = 4;

  logic clk = 0, rst = 1;
  logic fetch_valid = 0, is_dword = 0, is_skip = 0, cond_true = 0, pc_change = 0, next_dword = 0;
  logic [23:0] fetch_word = 0;
  logic [1:0] mc_class = 0;
  logic issue_valid, nop_insert, busy;
  logic [1:0] word_consume;
  logic [PW-1:0] word_ptr;

  int checks = 0, fails = 0;
  int q[$];
  int mptr = 0;

  always #2.5 clk = ~clk;

  issue_seq #(.PTR_W(PW)) u_dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .is_dword(is_dword), .is_skip(is_skip), .cond_true(cond_true), .pc_change(pc_change),
    .mc_class(mc_class), .next_dword(next_dword), .issue_valid(issue_valid),
    .nop_insert(nop_insert), .word_consume(word_consume), .busy(busy), .word_ptr(word_ptr));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit fv, input logic [23:0] w, input bit dw, input bit sk,
                      input bit ct, input bit pc, input logic [1:0] mc, input bit nd,
                      input string tag);
    int eiv, enop, econs, ebusy, tot;
    string t;
    @(negedge clk);
    fetch_valid = fv; fetch_word = w; is_dword = dw; is_skip = sk;
    cond_true = ct; pc_change = pc; mc_class = mc; next_dword = nd;
    #1;
    t = tag; eiv = 0; enop = 0; econs = 0; ebusy = 0;
    if (q.size() > 0) begin
      int k;
      k = q.pop_front();
      enop = (k == 1); ebusy = 1;
      t = (k == 1) ? "R9/R10" : "R4/R10";
    end else if (fv) begin
      if (w[23:16] == 0) begin
        enop = 1; econs = 1; tot = 1; t = "R8";
      end else begin
        eiv = 1; econs = 1;
        if (dw) tot = 2;
        else if (mc == 1) tot = 2;
        else if (mc == 2) tot = 3;
        else if (mc == 3) tot = 3;
        else if (sk) tot = ct ? (nd ? 3 : 2) : 1;
        else tot = (ct || pc) ? 2 : 1;
        if (dw) econs = 2;
        else if (mc == 0 && sk) econs = tot;
        for (int i = 1; i < tot; i++) q.push_back(dw ? 2 : 1);
      end
    end
    chk(t, "issue_valid", int'(issue_valid), eiv);
    chk(t, "nop_insert", int'(nop_insert), enop);
    chk(t, "word_consume", int'(word_consume), econs);
    chk(t, "busy", int'(busy), ebusy);
    chk("R11", "word_ptr", int'(word_ptr), mptr);
    mptr = (mptr + econs) % (1 << PW);
  endtask

  task automatic drain();
    while (q.size() > 0)
      step(1, 24'(32'h00C000 | $urandom_range(0, 4095)), $urandom_range(0, 1), 1, 1, 1, 2'd3, 1, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic instr(input logic [23:0] w, input bit dw, input bit sk, input bit ct,
                       input bit pc, input logic [1:0] mc, input bit nd, input string tag);
    step(1, w, dw, sk, ct, pc, mc, nd, tag);
    drain();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; fetch_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    q.delete();
    mptr = 0;
    chk("R1", "word_ptr after reset", int'(word_ptr), 0);
    chk("R1", "busy after reset", int'(busy), 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    instr(24'h123456, 0, 0, 0, 0, 0, 0, "R2");
    instr(24'hA10001, 0, 0, 1, 0, 0, 0, "R3");
    instr(24'hA20002, 0, 0, 0, 1, 0, 0, "R3");
    instr(24'h0F1111, 1, 0, 0, 0, 0, 0, "R4");
    instr(24'h0F2222, 1, 1, 1, 1, 2'd2, 1, "R4");
    instr(24'h300001, 0, 0, 0, 0, 2'd1, 0, "R5");
    instr(24'h300002, 0, 0, 0, 0, 2'd2, 0, "R5");
    instr(24'h300003, 0, 1, 1, 1, 2'd3, 1, "R5");
    instr(24'h440000, 0, 1, 0, 0, 0, 1, "R6");
    instr(24'h450000, 0, 1, 1, 0, 0, 0, "R7");
    instr(24'h460000, 0, 1, 1, 0, 0, 1, "R7");
    instr(24'h00ABCD, 1, 1, 1, 1, 2'd2, 1, "R8");
    instr(24'h00FFFF, 0, 0, 1, 0, 0, 0, "R8");
    step(1, 24'h300002, 0, 0, 0, 0, 2'd2, 0, "R5");
    do_reset();
    step(1, 24'h777777, 0, 0, 0, 0, 0, 0, "R1");
    for (int n = 0; n < 400; n++) begin
      logic [23:0] w;
      w = 24'($urandom);
      if ($urandom_range(0, 7) == 0) w[23:16] = 0;
      step($urandom_range(0, 3) != 0, w, $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 1), $urandom_range(0, 3) == 0,
           ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'd0,
           $urandom_range(0, 1), "R11");
    end
    drain();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule